// File: doc/BRIEF.md
# Pipelined RC5-32/12 Block Encryptor

This block encrypts 64-bit blocks with the RC5 cipher at 32-bit words and 12 rounds. Each block is given as two 32-bit halves. The datapath is fully unrolled into a chain of registered stages: one whitening stage, then one stage per round. A fresh block can therefore enter on every clock edge, and its ciphertext appears a fixed number of cycles later.

The expanded key table has 26 words. It is held on chip inside the block and is filled through a simple write port before traffic starts. Key expansion itself happens elsewhere. Every stage reads its own pair of table words, so the table is consumed in index order as a block moves down the chain. Both the word count and the round count are parameters.

Top module: `rc5_pipe_enc`

## Requirements
- R1: Reset is synchronous and active high. While reset is applied, and in the first cycle after it, `out_valid` is 0. Blocks that were in flight when reset arrived never show up at the output.
- R2: A block accepted with `in_valid`=1 at clock edge n is presented with `out_valid`=1 in the cycle after edge n+12, which is a latency of 13 cycles. Back-to-back blocks come out back to back, in input order, one per cycle.
- R3: The whitening stage adds table word 0 to half A and table word 1 to half B, modulo 2^32.
- R4: Round i, for i from 1 to 12, first sets A to ((A xor B) rotated left by B[4:0]) + word 2i. It then sets B to ((B xor newA) rotated left by newA[4:0]) + word 2i+1. A rotate amount of 0 leaves the word unchanged.
- R5: `out_data` is {A, B}: the final A sits in bits 63:32 and the final B in bits 31:0.
- R6: A write with `key_we`=1 stores `key_wdata` at table index `key_addr` for indices 0 to 25. Writes to indices 26 to 31 change nothing.
- R7: A table write sampled at a clock edge is seen by every stage computation after that edge, and not before it. A block entering at the same edge as a write to word 0 uses the old word 0. A block entering at the same edge as a write to word 25 uses the new word 25.
- R8: With the table expanded from an all-zero 16-byte key, the plaintext A=0, B=0 encrypts to `out_data` = 64'hEEDBA521_6D8F4B15.
- R9: Cycles with `in_valid`=0 produce no output: the output cycle that would belong to them has `out_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_we | input | 1 | Table write strobe |
| key_addr | input | 5 | Table word index |
| key_wdata | input | 32 | Table word to store |
| in_valid | input | 1 | Plaintext block present |
| in_a | input | 32 | Plaintext half A |
| in_b | input | 32 | Plaintext half B |
| out_valid | output | 1 | Ciphertext block present |
| out_data | output | 64 | Ciphertext {A, B} |

## Verification
A table write and a block's use of that table entry can fall in the same cycle. This happens either because both arrive at the same edge, or because the write lands while a block is partway down the chain. The bench provokes both ends of this case. It writes word 0 in the very cycle a block enters, and expects the old value to be used. It writes word 25 in the very cycle a block enters, and expects the new value, since the last round reads that word twelve edges later. A scoreboard with a reference model built from the round equations judges each result, and it also checks the exact output cycle of every block.

// File: rtl/rc5_pipe_enc.sv
module rc5_pipe_enc #(
  parameter int WORD   = 32,
  parameter int ROUNDS = 12,
  parameter int KEY_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_we,
  input  logic [KEY_AW-1:0] key_addr,
  input  logic [WORD-1:0]   key_wdata,
  input  logic              in_valid,
  input  logic [WORD-1:0]   in_a,
  input  logic [WORD-1:0]   in_b,
  output logic              out_valid,
  output logic [2*WORD-1:0] out_data
);

  localparam int NKEY = 2 * (ROUNDS + 1);
  localparam int SH   = $clog2(WORD);
  localparam int LAT  = ROUNDS + 1;

  function automatic logic [WORD-1:0] rotl(input logic [WORD-1:0] x, input logic [SH-1:0] n);
    logic [2*WORD-1:0] d;
    d = {x, x} << n;
    return d[2*WORD-1:WORD];
  endfunction

  logic [WORD-1:0] skey [NKEY];

  always_ff @(posedge clk)
    for (int k = 0; k < NKEY; k++)
      if (key_we && key_addr == KEY_AW'(k)) skey[k] <= key_wdata;

  logic [LAT-1:0]  vld;
  logic [WORD-1:0] va [LAT];
  logic [WORD-1:0] vb [LAT];
  logic [WORD-1:0] na [1:ROUNDS];
  logic [WORD-1:0] nb [1:ROUNDS];

  always_comb
    for (int r = 1; r <= ROUNDS; r++) begin
      na[r] = rotl(va[r-1] ^ vb[r-1], vb[r-1][SH-1:0]) + skey[2*r];
      nb[r] = rotl(vb[r-1] ^ na[r], na[r][SH-1:0]) + skey[2*r+1];
    end

  always_ff @(posedge clk)
    if (rst) vld <= '0;
    else     vld <= {vld[LAT-2:0], in_valid};

  always_ff @(posedge clk) begin
    va[0] <= in_a + skey[0];
    vb[0] <= in_b + skey[1];
    for (int r = 1; r <= ROUNDS; r++) begin
      va[r] <= na[r];
      vb[r] <= nb[r];
    end
  end

  assign out_valid = vld[ROUNDS];
  assign out_data  = {va[ROUNDS], vb[ROUNDS]};

  int unsigned since_rst;
  int unsigned inflight;

  always_ff @(posedge clk)
    if (rst) begin
      since_rst <= 0;
      inflight  <= 0;
    end else begin
      if (since_rst < LAT) since_rst <= since_rst + 1;
      inflight <= inflight + int'(in_valid) - int'(out_valid);
    end

  p_rst_clear_r1: assert property (@(posedge clk) rst |=> !out_valid);

  p_min_latency_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> since_rst >= LAT);

  p_inflight_bound_r2: assert property (@(posedge clk) disable iff (rst)
    inflight <= LAT);

  p_out_has_source_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> inflight > 0);

  for (genvar k = 0; k < NKEY; k++) begin : g_chk
    p_bad_addr_r6: assert property (@(posedge clk) disable iff (rst)
      (key_we && int'(key_addr) >= NKEY) |=> $stable(skey[k]));
  end

endmodule

// File: tb/rc5_pipe_enc_test.sv
`timescale 1ns/1ps
module rc5_pipe_enc_test;

  logic        clk = 0;
  logic        rst = 1;
  logic        key_we = 0;
  logic [4:0]  key_addr = 0;
  logic [31:0] key_wdata = 0;
  logic        in_valid = 0;
  logic [31:0] in_a = 0, in_b = 0;
  logic        out_valid;
  logic [63:0] out_data;

  rc5_pipe_enc uut (
    .clk(clk), .rst(rst), .key_we(key_we), .key_addr(key_addr), .key_wdata(key_wdata),
    .in_valid(in_valid), .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] tb_key [26];
  logic [63:0] exp_q [$];
  int          due_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (n == 0) ? x : ((x << n) | (x >> (32 - n)));
  endfunction

  function automatic logic [63:0] model(input logic [31:0] a0, input logic [31:0] b0);
    logic [31:0] a, b;
    a = a0 + tb_key[0];
    b = b0 + tb_key[1];
    for (int i = 1; i <= 12; i++) begin
      a = rl(a ^ b, int'(b[4:0])) + tb_key[2*i];
      b = rl(b ^ a, int'(a[4:0])) + tb_key[2*i+1];
    end
    return {a, b};
  endfunction

  task automatic zero_key_expand();
    logic [31:0] l [4];
    logic [31:0] a, b;
    int i, j;
    for (int k = 0; k < 4; k++) l[k] = 0;
    tb_key[0] = 32'hB7E15163;
    for (int k = 1; k < 26; k++) tb_key[k] = tb_key[k-1] + 32'h9E3779B9;
    a = 0; b = 0; i = 0; j = 0;
    for (int k = 0; k < 78; k++) begin
      tb_key[i] = rl(tb_key[i] + a + b, 3);
      a = tb_key[i];
      l[j] = rl(l[j] + a + b, int'((a + b) & 32'd31));
      b = l[j];
      i = (i + 1) % 26;
      j = (j + 1) % 4;
    end
  endtask

  task automatic fail(input string req, input logic [63:0] act, input logic [63:0] exp);
    errors++;
    $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) fail(req, act, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 0;
      key_we = 0;
    end
  endtask

  task automatic kwrite(input int addr, input logic [31:0] d);
    @(negedge clk);
    in_valid = 0;
    key_we = 1; key_addr = 5'(addr); key_wdata = d;
    if (addr < 26) tb_key[addr] = d;
  endtask

  task automatic send_exp(input logic [31:0] a, input logic [31:0] b, input logic [63:0] e);
    @(negedge clk);
    key_we = 0;
    in_valid = 1; in_a = a; in_b = b;
    exp_q.push_back(e);
    due_q.push_back(cyc + 13);
  endtask

  task automatic send(input logic [31:0] a, input logic [31:0] b);
    send_exp(a, b, model(a, b));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          checks++;
          fail("R9 unexpected output", out_data, 64'h0);
        end else begin
          logic [63:0] e;
          int d;
          e = exp_q.pop_front();
          d = due_q.pop_front();
          check("R2 latency", 64'(cyc), 64'(d));
          check("R3 R4 R5 ciphertext", out_data, e);
        end
      end else if (due_q.size() != 0 && cyc > due_q[0]) begin
        checks++;
        fail("R2 missing output", 64'(cyc), 64'(due_q[0]));
        void'(exp_q.pop_front());
        void'(due_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid during reset", 64'(out_valid), 64'h0);
    rst = 0;
    @(negedge clk);
    check("R1 out_valid after reset", 64'(out_valid), 64'h0);

    // R8 zero-key vector
    zero_key_expand();
    check("R8 model vs vector", model(0, 0), 64'hEEDBA521_6D8F4B15);
    for (int k = 0; k < 26; k++) kwrite(k, tb_key[k]);
    send_exp(0, 0, 64'hEEDBA521_6D8F4B15);
    idle(16);

    // R2 back-to-back stream
    for (int i = 0; i < 24; i++) send($urandom, $urandom);
    idle(16);

    // R9 gapped stream
    for (int i = 0; i < 10; i++) begin
      send($urandom, $urandom);
      idle(i % 3);
    end
    idle(16);

    // R4 rotate amount corners
    send(32'h0000_0000, 32'h0000_0020);
    send(32'hFFFF_FFFF, 32'h0000_001F);
    send(32'h8000_0001, 32'hFFFF_FFE0);
    send(32'h1234_5678, 32'h0000_0001);
    idle(16);

    // new random key table
    for (int k = 0; k < 26; k++) kwrite(k, $urandom);
    for (int i = 0; i < 8; i++) send($urandom, $urandom);
    idle(16);

    // R6 out-of-range writes ignored
    kwrite(26, 32'hDEAD_BEEF);
    kwrite(31, 32'hCAFE_F00D);
    for (int i = 0; i < 4; i++) send($urandom, $urandom);
    idle(16);

    // R7 write to word 0 in the entry cycle: old word used
    begin
      logic [31:0] a, b, nk;
      logic [63:0] e;
      a = $urandom; b = $urandom; nk = $urandom ^ 32'h5A5A_0001;
      e = model(a, b);
      @(negedge clk);
      in_valid = 1; in_a = a; in_b = b;
      key_we = 1; key_addr = 5'd0; key_wdata = nk;
      exp_q.push_back(e);
      due_q.push_back(cyc + 13);
      tb_key[0] = nk;
      idle(16);
      // R7 write to word 25 in the entry cycle: new word used
      a = $urandom; b = $urandom; nk = tb_key[25] ^ 32'h0F0F_0F0F;
      tb_key[25] = nk;
      e = model(a, b);
      @(negedge clk);
      in_valid = 1; in_a = a; in_b = b;
      key_we = 1; key_addr = 5'd25; key_wdata = nk;
      exp_q.push_back(e);
      due_q.push_back(cyc + 13);
      idle(16);
      send($urandom, $urandom);
      idle(16);
    end

    // R1 reset with blocks in flight
    for (int i = 0; i < 4; i++) send($urandom, $urandom);
    idle(2);
    @(negedge clk);
    rst = 1;
    in_valid = 0;
    exp_q.delete();
    due_q.delete();
    idle(2);
    rst = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      check("R1 flushed block absent", 64'(out_valid), 64'h0);
    end

    send($urandom, $urandom);
    idle(20);
    check("R2 all blocks delivered", 64'(exp_q.size()), 64'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule